// File: doc/BRIEF.md
# Inter-Thread Doorbell Message Unit

This unit lets the hardware threads of one processor signal each other. Every thread owns a small issue port through which it presents a message operation together with a 64-bit operand. A send whose operand carries the doorbell message type marks a doorbell as pending on every other thread whose identification value matches the 20-bit tag carried in the operand. The sending thread is never a target, even if its own identification value matches the tag.

Pending doorbells are held in one sticky bit per thread and leave the unit as per-thread interrupt lines. A thread removes its own doorbell with an ordinary clear. A separate privileged pending-status vector, which the configuration port can set, is cleared by a privileged clear. All issue ports may be active in the same cycle. Where a set and a clear meet on one bit, the set wins, so no message is lost. Each thread's identification value is written through the same configuration port.

Top module: `dbell_unit`

## Requirements
- R1: After reset, every pendIrq and pendStatus bit is 0, and the identification value of thread t is t.
- R2: A valid send from thread i with operand bits [31:27] equal to 5 sets pendIrq[j] in the next cycle for every thread j other than i whose identification bits [19:0] equal operand bits [19:0]. Operand bits outside [31:27] and [19:0] do not affect matching.
- R3: An operation whose operand bits [31:27] differ from 5 has no effect, whatever its kind.
- R4: A send never sets the pending bit of its own issuing thread.
- R5: A pending bit stays 1 until a clear removes it, and a further send to an already pending thread leaves it at 1.
- R6: A valid clear (opKind 1) with type 5 from thread t sets pendIrq[t] to 0 in the next cycle and leaves every other pending bit unchanged.
- R7: A valid privileged clear (opKind 2) with type 5 from thread t ≥ 1, with opPriv[t] high, sets pendStatus[t-1] to 0. The same operation from thread 0 changes nothing.
- R8: A privileged clear presented with opPriv low is ignored.
- R9: The synchronising operation (opKind 3) changes no state.
- R10: When a set and a clear reach the same pendIrq or pendStatus bit in the same cycle, the bit ends at 1.
- R11: A configuration write with cfgSel 0 replaces the identification value of thread cfgThread, and later sends match against the new value. A write with cfgSel 1 ORs cfgData[N-1:0] into pendStatus. Both take effect one cycle later.
- R12: Sends from several threads in one cycle set the union of their targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | NUM_THREADS | Per-thread operation valid |
| opKind | input | 2*NUM_THREADS | Per-thread kind, 2 bits each: 0 send, 1 clear, 2 privileged clear, 3 synchronise |
| opPriv | input | NUM_THREADS | Issuing thread is in privileged state |
| opData | input | 64*NUM_THREADS | Per-thread 64-bit operand |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 writes an identification value, 1 sets pendStatus bits |
| cfgThread | input | clog2(NUM_THREADS) | Thread whose identification value is written |
| cfgData | input | 32 | Configuration write data |
| pendIrq | output | NUM_THREADS | Per-thread pending doorbell interrupt |
| pendStatus | output | NUM_THREADS | Privileged pending-status vector |

## Verification
The bench builds the unit with four threads, a 20-bit tag and 32-bit identification values. With four threads there are twelve distinct sender-target pairs. Thread 0 exists to show that its privileged clear does nothing, and the top thread to show that no status bit sits above it. Identification values are drawn from a small set of tags, so random traffic often produces several matches, self-matches and set-against-clear collisions in a single cycle. Directed cycles cover the exact corners named in the requirements.

// File: rtl/dbell_pkg.sv
`timescale 1ns/1ps
package dbell_pkg;
  typedef enum logic [1:0] {
    OP_SEND       = 2'd0,
    OP_CLEAR      = 2'd1,
    OP_CLEAR_PRIV = 2'd2,
    OP_SYNC       = 2'd3
  } dbOp_e;

  // per-thread strobes from control to datapath
  typedef struct packed {
    logic send;
    logic clrSelf;
    logic clrPriv;
  } dbStrobe_t;
endpackage

// File: rtl/dbell_ctrl.sv
`timescale 1ns/1ps
module dbell_ctrl import dbell_pkg::*; #(
  parameter int NUM_THREADS = 4,
  parameter int OP_W        = 64,
  parameter int TYPE_LSB    = 27,
  parameter int TYPE_W      = 5,
  parameter int BELL_TYPE   = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_THREADS-1:0]      opValid,
  input  logic [2*NUM_THREADS-1:0]    opKind,
  input  logic [NUM_THREADS-1:0]      opPriv,
  input  logic [OP_W*NUM_THREADS-1:0] opData,
  output dbStrobe_t [NUM_THREADS-1:0] strobes
);
  localparam logic [TYPE_W-1:0] BELL_CODE = TYPE_W'(BELL_TYPE);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_dec
    logic  typeOk;
    dbOp_e kind;
    assign typeOk = (opData[t*OP_W + TYPE_LSB +: TYPE_W] == BELL_CODE);
    assign kind   = dbOp_e'(opKind[2*t +: 2]);

    assign strobes[t].send    = opValid[t] && typeOk && (kind == OP_SEND);
    assign strobes[t].clrSelf = opValid[t] && typeOk && (kind == OP_CLEAR);

    if (t == 0) begin : g_noStatus
      // thread 0 has no status bit below it
      assign strobes[t].clrPriv = 1'b0;
    end else begin : g_status
      assign strobes[t].clrPriv = opValid[t] && typeOk && opPriv[t] &&
                                  (kind == OP_CLEAR_PRIV);
    end

    assert_priv_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobes[t].clrPriv |-> opPriv[t]);
    assert_one_action_R9: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strobes[t].send, strobes[t].clrSelf, strobes[t].clrPriv}));
  end
endmodule

// File: rtl/dbell_dpath.sv
`timescale 1ns/1ps
module dbell_dpath import dbell_pkg::*; #(
  parameter int NUM_THREADS = 4,
  parameter int OP_W        = 64,
  parameter int PID_W       = 32,
  parameter int TAG_W       = 20,
  parameter int TIDX_W      = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dbStrobe_t [NUM_THREADS-1:0] strobes,
  input  logic [OP_W*NUM_THREADS-1:0] opData,
  input  logic                        cfgWe,
  input  logic                        cfgSel,
  input  logic [TIDX_W-1:0]           cfgThread,
  input  logic [PID_W-1:0]            cfgData,
  output logic [NUM_THREADS-1:0]      pendIrq,
  output logic [NUM_THREADS-1:0]      pendStatus
);
  logic [PID_W-1:0]       idReg [NUM_THREADS];
  logic [NUM_THREADS-1:0] setHit, clrSelf, privClr, statSet, sendVec;

  // tag comparison: every sender against every other thread
  always_comb begin
    setHit = '0;
    for (int j = 0; j < NUM_THREADS; j++) begin
      for (int i = 0; i < NUM_THREADS; i++) begin
        if (i != j && strobes[i].send &&
            idReg[j][TAG_W-1:0] == opData[i*OP_W +: TAG_W])
          setHit[j] = 1'b1;
      end
    end
  end

  always_comb begin
    privClr = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      sendVec[k] = strobes[k].send;
      clrSelf[k] = strobes[k].clrSelf;
      if (k + 1 < NUM_THREADS) privClr[k] = strobes[k+1].clrPriv;
    end
    statSet = (cfgWe && cfgSel) ? cfgData[NUM_THREADS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIrq    <= '0;
      pendStatus <= '0;
      for (int t = 0; t < NUM_THREADS; t++) idReg[t] <= PID_W'(t);
    end else begin
      // set is applied after clear, so it wins
      pendIrq    <= (pendIrq & ~clrSelf) | setHit;
      pendStatus <= (pendStatus & ~privClr) | statSet;
      for (int t = 0; t < NUM_THREADS; t++)
        if (cfgWe && !cfgSel && cfgThread == TIDX_W'(t)) idReg[t] <= cfgData;
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      pendIrq[t] && !clrSelf[t] |=> pendIrq[t]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      clrSelf[t] && !setHit[t] |=> !pendIrq[t]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      setHit[t] |=> pendIrq[t]);
    assert_stat_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      privClr[t] && !statSet[t] |=> !pendStatus[t]);
    assert_stat_set_R11: assert property (@(posedge clk) disable iff (!rstN)
      statSet[t] |=> pendStatus[t]);
    assert_self_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
      sendVec[t] && $countones(sendVec) == 1 && !pendIrq[t] |=> !pendIrq[t]);
  end
endmodule

// File: rtl/dbell_unit.sv
`timescale 1ns/1ps
module dbell_unit import dbell_pkg::*; #(
  parameter int NUM_THREADS = 4,
  parameter int OP_W        = 64,
  parameter int PID_W       = 32,
  parameter int TAG_W       = 20,
  parameter int TYPE_LSB    = 27,
  parameter int TYPE_W      = 5,
  parameter int BELL_TYPE   = 5,
  localparam int TIDX_W     = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_THREADS-1:0]      opValid,
  input  logic [2*NUM_THREADS-1:0]    opKind,
  input  logic [NUM_THREADS-1:0]      opPriv,
  input  logic [OP_W*NUM_THREADS-1:0] opData,
  input  logic                        cfgWe,
  input  logic                        cfgSel,
  input  logic [TIDX_W-1:0]           cfgThread,
  input  logic [PID_W-1:0]            cfgData,
  output logic [NUM_THREADS-1:0]      pendIrq,
  output logic [NUM_THREADS-1:0]      pendStatus
);
  dbStrobe_t [NUM_THREADS-1:0] strobes;

  dbell_ctrl #(
    .NUM_THREADS(NUM_THREADS), .OP_W(OP_W), .TYPE_LSB(TYPE_LSB),
    .TYPE_W(TYPE_W), .BELL_TYPE(BELL_TYPE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opPriv(opPriv), .opData(opData), .strobes(strobes)
  );

  dbell_dpath #(
    .NUM_THREADS(NUM_THREADS), .OP_W(OP_W), .PID_W(PID_W),
    .TAG_W(TAG_W), .TIDX_W(TIDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opData(opData),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgThread(cfgThread), .cfgData(cfgData),
    .pendIrq(pendIrq), .pendStatus(pendStatus)
  );

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid == '0 && !cfgWe) |=> ($stable(pendIrq) && $stable(pendStatus)));
endmodule

// File: tb/dbell_unit_test.sv
`timescale 1ns/1ps
module dbell_unit_test;
  localparam int N = 4;
  localparam int TW = 2;

  logic            clk = 1'b0;
  logic            rstN;
  logic [N-1:0]    opValid, opPriv;
  logic [2*N-1:0]  opKind;
  logic [64*N-1:0] opData;
  logic            cfgWe, cfgSel;
  logic [TW-1:0]   cfgThread;
  logic [31:0]     cfgData;
  logic [N-1:0]    pendIrq, pendStatus;

  logic [N-1:0] mPend, mStat;
  logic [31:0]  mId [N];
  int total = 0, bad = 0;
  bit finished = 0;

  dbell_unit #(.NUM_THREADS(N)) uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opPriv(opPriv), .opData(opData), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgThread(cfgThread), .cfgData(cfgData),
    .pendIrq(pendIrq), .pendStatus(pendStatus)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] mk(logic [19:0] tag, logic [4:0] typ);
    logic [31:0] hi  = $urandom;
    logic [6:0]  mid = 7'($urandom);
    return {hi, typ, mid, tag};
  endfunction

  function automatic bit isBell(logic [63:0] d);
    return d[31:27] == 5'd5;
  endfunction

  task automatic clearIn();
    opValid = '0; opKind = '0; opPriv = '0; opData = '0;
    cfgWe = 0; cfgSel = 0; cfgThread = '0; cfgData = '0;
  endtask

  task automatic setOp(int t, logic [1:0] kind, logic [63:0] d, logic priv);
    opValid[t] = 1'b1;
    opKind[t*2 +: 2] = kind;
    opData[t*64 +: 64] = d;
    opPriv[t] = priv;
  endtask

  task automatic check(string req);
    total++;
    if (pendIrq !== mPend || pendStatus !== mStat) begin
      bad++;
      $display("FAIL %s: pendIrq=%h exp=%h pendStatus=%h exp=%h",
               req, pendIrq, mPend, pendStatus, mStat);
    end
  endtask

  // model one clock edge from the requirements, then compare
  task automatic runCycle(string req);
    logic [N-1:0] nPend = mPend, nStat = mStat;
    for (int t = 0; t < N; t++) begin
      logic [63:0] d = opData[t*64 +: 64];
      logic [1:0]  k = opKind[t*2 +: 2];
      if (opValid[t] && isBell(d)) begin
        if (k == 2'd1) nPend[t] = 1'b0;                               // R6
        if (k == 2'd2 && opPriv[t] && t >= 1) nStat[t-1] = 1'b0;      // R7 R8
      end
    end
    for (int i = 0; i < N; i++) begin
      logic [63:0] d = opData[i*64 +: 64];
      if (opValid[i] && isBell(d) && opKind[i*2 +: 2] == 2'd0)
        for (int j = 0; j < N; j++)
          if (j != i && mId[j][19:0] == d[19:0]) nPend[j] = 1'b1;     // R2 R4 R10 R12
    end
    if (cfgWe && cfgSel) nStat = nStat | cfgData[N-1:0];              // R11
    @(posedge clk);
    #5;
    mPend = nPend; mStat = nStat;
    if (cfgWe && !cfgSel) mId[cfgThread] = cfgData;
    check(req);
    @(negedge clk);
    clearIn();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    clearIn();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    mPend = '0; mStat = '0;
    for (int t = 0; t < N; t++) mId[t] = 32'(t);
    check("R1 reset");

    setOp(0, 2'd0, mk(20'd1, 5'd5), 0);  runCycle("R1 id is index");
    setOp(1, 2'd1, mk(20'd0, 5'd5), 0);  runCycle("R6 clear self");
    setOp(1, 2'd0, mk(20'd1, 5'd5), 0);  runCycle("R4 sender excluded");
    cfgWe = 1; cfgSel = 0; cfgThread = 2; cfgData = 32'hFFFA_BCDE;
    runCycle("R11 id write");
    setOp(3, 2'd0, mk(20'hABCDE, 5'd5), 0); runCycle("R2 tag match");
    setOp(0, 2'd0, mk(20'd3, 5'd4), 0);
    setOp(2, 2'd1, mk(20'd0, 5'd6), 0);  runCycle("R3 wrong type");
    setOp(0, 2'd0, mk(20'hABCDE, 5'd5), 0); runCycle("R5 repeat send");
    for (int t = 0; t < N; t++) setOp(t, 2'd3, mk(20'd2, 5'd5), 1);
    runCycle("R9 sync");
    cfgWe = 1; cfgSel = 1; cfgData = 32'hF; runCycle("R11 status set");
    setOp(2, 2'd2, mk(20'd0, 5'd5), 1);  runCycle("R7 priv clear");
    setOp(0, 2'd2, mk(20'd0, 5'd5), 1);  runCycle("R7 thread0");
    setOp(3, 2'd2, mk(20'd0, 5'd5), 0);  runCycle("R8 unprivileged");
    setOp(1, 2'd0, mk(20'hABCDE, 5'd5), 0);
    setOp(2, 2'd1, mk(20'd0, 5'd5), 0);  runCycle("R10 pend collision");
    setOp(1, 2'd2, mk(20'd0, 5'd5), 1);
    cfgWe = 1; cfgSel = 1; cfgData = 32'h1; runCycle("R10 status collision");
    for (int t = 0; t < N; t++) setOp(t, 2'd1, mk(20'd0, 5'd5), 0);
    runCycle("R6 clear all");
    cfgWe = 1; cfgSel = 0; cfgThread = 0; cfgData = 32'h7; runCycle("R11 id0");
    cfgWe = 1; cfgSel = 0; cfgThread = 3; cfgData = 32'h7; runCycle("R11 id3");
    setOp(1, 2'd0, mk(20'd7, 5'd5), 0);
    setOp(3, 2'd0, mk(20'hABCDE, 5'd5), 0); runCycle("R12 union");

    for (int n = 0; n < 2000; n++) begin
      for (int t = 0; t < N; t++) begin
        if ($urandom % 2 == 0) begin
          logic [4:0] typ = ($urandom % 4 != 0) ? 5'd5 : 5'($urandom);
          setOp(t, 2'($urandom), mk(20'($urandom % 8), typ), 1'($urandom));
        end
      end
      if ($urandom % 8 == 0) begin
        cfgWe = 1; cfgSel = 1'($urandom); cfgThread = TW'($urandom);
        cfgData = cfgSel ? 32'($urandom) : {12'($urandom), 20'($urandom % 8)};
      end
      runCycle("R12 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule